// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block lets a host use one fixed address map while the device behind it moves its memory and register regions between operating stages. It keeps four programmable windows, three for memory and one for registers. They sit back to back in the host map: window 0 starts at host offset 0, and each later window starts where the one before it ends. A host address that falls inside a window becomes a physical address equal to that window's start plus the distance from the window's host base. An address beyond the last window is flagged as out of range and produces no translated access.

The windows are reprogrammed through a configuration request. The request captures a new set of window starts and sizes. The block then sends the settings to the device as seven 32-bit register writes, each held until the device acknowledges it. The request carries one start for each window and a size for the first three windows only. The last window, which maps registers, has a fixed host span given by a parameter. While a burst is running, translation requests are stalled. The new map is used only after the device acknowledges the final write.

Top module: `wpart_xlate`

## Requirements
- R1: After reset `cfg_busy`, `xl_stall`, `dw_valid`, `out_valid` and `out_oor` are low. The active map has zero size for windows 0 to 2 and start 0 for window 3, so host addresses below `W3_SPAN` map one to one through window 3.
- R2: A `cfg_req` sampled while idle captures `cfg_start` and `cfg_size`, and `cfg_busy` is high from the next cycle on.
- R3: A burst makes exactly seven writes to addresses `REG_BASE + 4*k`, k = 0 to 6, in this order: start 0, size 0, start 1, size 1, start 2, size 2, start 3. Each value is zero-extended to `DW` bits. Start i is bits [i*AW +: AW] of `cfg_start`, and size i is bits [i*AW +: AW] of `cfg_size`.
- R4: Each write keeps `dw_valid`, `dw_addr` and `dw_data` unchanged until `dw_ack` is sampled high. The burst moves on by one write for each acknowledge.
- R5: A `cfg_req` sampled while busy is ignored. The values written for the rest of the burst and the map that takes effect are those from the accepted request.
- R6: Host bases are cumulative. Window i begins at the sum of the sizes of windows 0 to i-1. Windows 0 to 2 span their programmed sizes and window 3 spans `W3_SPAN`. The sums are not wrapped, so a window whose base is at or beyond 2^AW cannot be reached.
- R7: For a host address h in window i, `out_paddr` = (start_i + h - base_i) mod 2^AW and `out_win` = i.
- R8: A host address at or beyond the end of window 3 raises `out_oor` with `out_valid` low.
- R9: Results are registered. A request sampled at one clock edge produces its result after that edge. A cycle without `xl_req` leaves `out_valid` and `out_oor` low.
- R10: While a burst is in progress, `xl_stall` is high and requests give neither `out_valid` nor `out_oor`. The new map is used from the first request after the final acknowledge.
- R11: A window of size zero claims no host address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Request to load and send a new window set |
| cfg_start | input | 4*AW | Physical start of each window, window i at bits [i*AW +: AW] |
| cfg_size | input | 3*AW | Host span of windows 0 to 2, window i at bits [i*AW +: AW] |
| cfg_busy | output | 1 | Configuration burst in progress |
| dw_valid | output | 1 | Device register write pending |
| dw_addr | output | AW | Device register address of the pending write |
| dw_data | output | DW | Value of the pending write |
| dw_ack | input | 1 | Device accepts the pending write |
| xl_req | input | 1 | Translation request |
| xl_haddr | input | AW | Host address to translate |
| xl_stall | output | 1 | Translation requests are not served this cycle |
| out_valid | output | 1 | Translated access is valid |
| out_oor | output | 1 | Last request was out of range |
| out_win | output | 2 | Window that served the access |
| out_paddr | output | AW | Translated physical address |

## Verification
The assertions assume that the device keeps `dw_ack` low when no write is pending, and that a request made while `cfg_busy` is high is meant to be dropped, not queued. The stimulus raises `dw_ack` only while `dw_valid` is high and waits zero to two cycles before each acknowledge. In one burst it deliberately sends a translation request and a second configuration request with different values, so the stall and ignore properties are exercised rather than left idle. The host address is swept over the whole 12-bit space for several maps. These maps include empty windows, a translation that wraps past the top of the physical space, and windows pushed beyond the host space.

// File: rtl/wpart_pkg.sv
// Shared constants and types for the window partition translator.
// Assumes exactly four windows; the last has a parameter-fixed span.
package wpart_pkg;
    localparam int NUM_WIN   = 4;
    localparam int NUM_SIZED = NUM_WIN - 1;
    localparam int NUM_WR    = 2 * NUM_WIN - 1;
    localparam int WR_IDX_W  = $clog2(NUM_WR);
    localparam int WIN_IDX_W = $clog2(NUM_WIN);

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_e;
endpackage

// File: rtl/wpart_regs.sv
// Window register file: a pending set captured on an accepted request and
// an active set used by translation, updated from pending on commit.
// Assumes load and commit never coincide (load only when idle).
module wpart_regs
    import wpart_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    commit,
    input  logic                    busy,
    input  logic [NUM_WIN*AW-1:0]   cfg_start,
    input  logic [NUM_SIZED*AW-1:0] cfg_size,
    output logic [NUM_WIN*AW-1:0]   pend_start,
    output logic [NUM_SIZED*AW-1:0] pend_size,
    output logic [NUM_WIN*AW-1:0]   act_start,
    output logic [NUM_SIZED*AW-1:0] act_size
);

    // Capture the requested window set when a burst is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_start <= '0;
            pend_size  <= '0;
        end else if (load) begin
            pend_start <= cfg_start;
            pend_size  <= cfg_size;
        end
    end

    // Switch the translation map once the device has taken every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_start <= '0;
            act_size  <= '0;
        end else if (commit) begin
            act_start <= pend_start;
            act_size  <= pend_size;
        end
    end

    // Requests during a burst must not disturb the captured values.
    assert_pending_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(pend_start) && $stable(pend_size)));

    // The active map only changes at the edge that ends a burst.
    assert_commit_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(act_start) && $stable(act_size)) |-> $fell(busy));

endmodule

// File: rtl/wpart_seq.sv
// Configuration write sequencer: emits the pending window set as seven
// ordered register writes, each held until acknowledged.
// Assumes the device raises dw_ack only while dw_valid is high.
module wpart_seq
    import wpart_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DW       = 32,
    parameter logic [AW-1:0] REG_BASE = AW'('h400)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_req,
    input  logic                    dw_ack,
    input  logic [NUM_WIN*AW-1:0]   pend_start,
    input  logic [NUM_SIZED*AW-1:0] pend_size,
    output logic                    busy,
    output logic                    load,
    output logic                    commit,
    output logic                    dw_valid,
    output logic [AW-1:0]           dw_addr,
    output logic [DW-1:0]           dw_data
);

    localparam logic [WR_IDX_W-1:0] LAST_IDX = WR_IDX_W'(NUM_WR - 1);

    seq_state_e          state;
    logic [WR_IDX_W-1:0] idx;
    logic [AW-1:0]       fields [NUM_WR];

    // Order the write values: even slots carry starts, odd slots carry sizes.
    for (genvar g = 0; g < NUM_WR; g++) begin : g_field
        if (g % 2 == 0) begin : g_start
            assign fields[g] = pend_start[(g/2)*AW +: AW];
        end else begin : g_size
            assign fields[g] = pend_size[(g/2)*AW +: AW];
        end
    end

    // Decode handshake events from the current state.
    always_comb begin
        busy     = (state == SEQ_SEND);
        dw_valid = busy;
        load     = cfg_req && !busy;
        commit   = busy && dw_ack && (idx == LAST_IDX);
        dw_addr  = REG_BASE + (AW'(idx) << 2);
        dw_data  = DW'(fields[idx]);
    end

    // Step through the writes, one per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (cfg_req) begin
                        state <= SEQ_SEND;
                        idx   <= '0;
                    end
                end
                SEQ_SEND: begin
                    if (dw_ack) begin
                        if (idx == LAST_IDX) begin
                            state <= SEQ_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // A write without acknowledge stays on the bus unchanged.
    assert_hold_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_valid && !dw_ack) |=> (dw_valid && $stable(dw_addr) && $stable(dw_data)));

    // An acknowledged write that is not the last moves to the next register.
    assert_next_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_valid && dw_ack && idx != LAST_IDX) |=>
            (dw_valid && dw_addr == $past(dw_addr) + AW'(4)));

    // An accepted request always opens a burst.
    assert_start_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !busy) |=> (busy && dw_addr == REG_BASE));

endmodule

// File: rtl/wpart_decode.sv
// Range decoder and translator: computes cumulative host bases, finds the
// window holding the host address and forms the physical address.
// Assumes W3_SPAN fits in AW bits; sums are kept AW+2 bits wide, unwrapped.
module wpart_decode
    import wpart_pkg::*;
#(
    parameter int          AW      = 32,
    parameter int unsigned W3_SPAN = 32'h0010_0000
) (
    input  logic [AW-1:0]           haddr,
    input  logic [NUM_WIN*AW-1:0]   act_start,
    input  logic [NUM_SIZED*AW-1:0] act_size,
    output logic [NUM_WIN-1:0]      win_hits,
    output logic                    any_hit,
    output logic [WIN_IDX_W-1:0]    sel_win,
    output logic [AW-1:0]           paddr
);

    localparam int EW = AW + 2;

    logic [EW-1:0] lo   [NUM_WIN];
    logic [EW-1:0] hi   [NUM_WIN];
    logic [EW-1:0] span [NUM_WIN];
    logic [EW-1:0] hext;

    assign hext = EW'(haddr);

    // Build each window's host range from the sizes of those before it.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        if (g < NUM_SIZED) begin : g_sized
            assign span[g] = EW'(act_size[g*AW +: AW]);
        end else begin : g_fixed
            assign span[g] = EW'(W3_SPAN);
        end
        if (g == 0) begin : g_first
            assign lo[g] = '0;
        end else begin : g_chain
            assign lo[g] = hi[g-1];
        end
        assign hi[g]       = lo[g] + span[g];
        assign win_hits[g] = (hext >= lo[g]) && (hext < hi[g]);
    end

    // Pick the hit window and translate the address through it.
    always_comb begin
        sel_win = '0;
        paddr   = '0;
        any_hit = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_hits[i] && !any_hit) begin
                any_hit = 1'b1;
                sel_win = WIN_IDX_W'(i);
                paddr   = act_start[i*AW +: AW] + AW'(hext - lo[i]);
            end
        end
    end

endmodule

// File: rtl/wpart_xlate.sv
// Top of the window partition translator: ties together the register file,
// the configuration sequencer and the decoder, and registers the result.
// Assumes requests during a burst are dropped by the requester on xl_stall.
module wpart_xlate
    import wpart_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DW       = 32,
    parameter logic [AW-1:0] REG_BASE = AW'('h400),
    parameter int unsigned   W3_SPAN  = 32'h0010_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_req,
    input  logic [4*AW-1:0]         cfg_start,
    input  logic [3*AW-1:0]         cfg_size,
    output logic                    cfg_busy,
    output logic                    dw_valid,
    output logic [AW-1:0]           dw_addr,
    output logic [DW-1:0]           dw_data,
    input  logic                    dw_ack,
    input  logic                    xl_req,
    input  logic [AW-1:0]           xl_haddr,
    output logic                    xl_stall,
    output logic                    out_valid,
    output logic                    out_oor,
    output logic [1:0]              out_win,
    output logic [AW-1:0]           out_paddr
);

    logic                    load;
    logic                    commit;
    logic                    busy;
    logic [NUM_WIN*AW-1:0]   pend_start;
    logic [NUM_SIZED*AW-1:0] pend_size;
    logic [NUM_WIN*AW-1:0]   act_start;
    logic [NUM_SIZED*AW-1:0] act_size;
    logic [NUM_WIN-1:0]      win_hits;
    logic                    any_hit;
    logic [WIN_IDX_W-1:0]    sel_win;
    logic [AW-1:0]           paddr;
    logic                    serve;

    wpart_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .commit     (commit),
        .busy       (busy),
        .cfg_start  (cfg_start),
        .cfg_size   (cfg_size),
        .pend_start (pend_start),
        .pend_size  (pend_size),
        .act_start  (act_start),
        .act_size   (act_size)
    );

    wpart_seq #(.AW(AW), .DW(DW), .REG_BASE(REG_BASE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_req    (cfg_req),
        .dw_ack     (dw_ack),
        .pend_start (pend_start),
        .pend_size  (pend_size),
        .busy       (busy),
        .load       (load),
        .commit     (commit),
        .dw_valid   (dw_valid),
        .dw_addr    (dw_addr),
        .dw_data    (dw_data)
    );

    wpart_decode #(.AW(AW), .W3_SPAN(W3_SPAN)) u_dec (
        .haddr     (xl_haddr),
        .act_start (act_start),
        .act_size  (act_size),
        .win_hits  (win_hits),
        .any_hit   (any_hit),
        .sel_win   (sel_win),
        .paddr     (paddr)
    );

    // Expose the stall and decide whether a request is served this cycle.
    always_comb begin
        cfg_busy = busy;
        xl_stall = busy;
        serve    = xl_req && !busy;
    end

    // Register the translation result for one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_oor   <= 1'b0;
            out_win   <= '0;
            out_paddr <= '0;
        end else begin
            out_valid <= serve && any_hit;
            out_oor   <= serve && !any_hit;
            if (serve) begin
                out_win   <= 2'(sel_win);
                out_paddr <= paddr;
            end
        end
    end

    // Back-to-back windows never overlap.
    assert_one_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_hits));

    // Requests made during a burst produce nothing.
    assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && cfg_busy) |=> (!out_valid && !out_oor));

    // A cycle without a request leaves the result flags low.
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_req |=> (!out_valid && !out_oor));

    // A valid access and an out-of-range flag never appear together.
    assert_oor_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_oor |-> !out_valid);

endmodule

// File: tb/wpart_xlate_test.sv
// Sweeps the full 12-bit host space through several window maps and checks
// each configuration burst write by write against an arithmetic model.
module wpart_xlate_test;
    localparam int          AW    = 12;
    localparam int          DW    = 32;
    localparam int          SPACE = 1 << AW;
    localparam logic [AW-1:0] RB  = 12'h3C0;
    localparam int          W3    = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_req = 1'b0;
    logic [4*AW-1:0]   cfg_start = '0;
    logic [3*AW-1:0]   cfg_size = '0;
    logic              cfg_busy;
    logic              dw_valid;
    logic [AW-1:0]     dw_addr;
    logic [DW-1:0]     dw_data;
    logic              dw_ack = 1'b0;
    logic              xl_req = 1'b0;
    logic [AW-1:0]     xl_haddr = '0;
    logic              xl_stall;
    logic              out_valid;
    logic              out_oor;
    logic [1:0]        out_win;
    logic [AW-1:0]     out_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_start [4];
    int m_size  [3];
    int n_start [4];
    int n_size  [3];

    always #5 clk = ~clk;

    wpart_xlate #(.AW(AW), .DW(DW), .REG_BASE(RB), .W3_SPAN(W3)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_start(cfg_start),
        .cfg_size(cfg_size), .cfg_busy(cfg_busy), .dw_valid(dw_valid),
        .dw_addr(dw_addr), .dw_data(dw_data), .dw_ack(dw_ack), .xl_req(xl_req),
        .xl_haddr(xl_haddr), .xl_stall(xl_stall), .out_valid(out_valid),
        .out_oor(out_oor), .out_win(out_win), .out_paddr(out_paddr)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Expected result of one translation under the model map (R6, R7, R8, R11).
    task automatic model(input int a, output int v, output int w, output int p);
        int lo = 0;
        v = 0; w = 0; p = 0;
        for (int i = 0; i < 4; i++) begin
            int sp = (i < 3) ? m_size[i] : W3;
            if (v == 0 && a >= lo && a < lo + sp) begin
                v = 1; w = i; p = (m_start[i] + a - lo) % SPACE;
            end
            lo += sp;
        end
    endtask

    task automatic sweep(input string name);
        int v, w, p;
        for (int a = 0; a < SPACE; a++) begin
            xl_haddr = AW'(a);
            xl_req = 1'b1;
            @(negedge clk);
            model(a, v, w, p);
            check({name, " R7 valid"}, int'(out_valid), v);
            check({name, " R8 oor"}, int'(out_oor), 1 - v);
            if (v == 1) begin
                check({name, " R6 win"}, int'(out_win), w);
                check({name, " R7 paddr"}, int'(out_paddr), p);
            end
        end
        xl_req = 1'b0;
        @(negedge clk);
        check({name, " R9 quiet valid"}, int'(out_valid), 0);
        check({name, " R9 quiet oor"}, int'(out_oor), 0);
    endtask

    // Run a burst with n_* values; poke adds a stray request mid-burst (R5, R10).
    task automatic program_map(input bit poke);
        for (int i = 0; i < 4; i++) cfg_start[i*AW +: AW] = AW'(n_start[i]);
        for (int i = 0; i < 3; i++) cfg_size[i*AW +: AW] = AW'(n_size[i]);
        cfg_req = 1'b1;
        @(negedge clk);
        cfg_req = 1'b0;
        check("R2 busy after request", int'(cfg_busy), 1);
        for (int k = 0; k < 7; k++) begin
            int ea = int'(RB) + 4 * k;
            int ed = (k % 2 == 0) ? n_start[k/2] : n_size[k/2];
            check("R3 write valid", int'(dw_valid), 1);
            check("R3 write addr", int'(dw_addr), ea);
            check("R3 write data", int'(dw_data), ed);
            for (int d = 0; d < k % 3; d++) begin
                if (poke && k == 2 && d == 0) begin
                    cfg_start = ~cfg_start;
                    cfg_size = ~cfg_size;
                    cfg_req = 1'b1;
                    xl_req = 1'b1;
                    xl_haddr = '0;
                    check("R10 stall high", int'(xl_stall), 1);
                end
                @(negedge clk);
                if (poke && k == 2 && d == 0) begin
                    check("R10 no valid while busy", int'(out_valid), 0);
                    check("R10 no oor while busy", int'(out_oor), 0);
                    cfg_req = 1'b0;
                    xl_req = 1'b0;
                end
                check("R4 held addr", int'(dw_addr), ea);
                check("R4 held data", int'(dw_data), ed);
                check("R5 still busy", int'(cfg_busy), 1);
            end
            dw_ack = 1'b1;
            @(negedge clk);
            dw_ack = 1'b0;
        end
        check("R3 burst ends busy", int'(cfg_busy), 0);
        check("R3 burst ends valid", int'(dw_valid), 0);
        check("R10 stall released", int'(xl_stall), 0);
        for (int i = 0; i < 4; i++) m_start[i] = n_start[i];
        for (int i = 0; i < 3; i++) m_size[i] = n_size[i];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) m_start[i] = 0;
        for (int i = 0; i < 3; i++) m_size[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", int'(cfg_busy), 0);
        check("R1 stall", int'(xl_stall), 0);
        check("R1 dw_valid", int'(dw_valid), 0);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_oor", int'(out_oor), 0);
        sweep("R1 reset map");

        n_start = '{12'h400, 12'h010, 12'hA00, 12'hF80};
        n_size  = '{12'h100, 12'h080, 12'h200};
        program_map(1'b1);
        sweep("R10 new map with wrap");

        n_start = '{12'h123, 12'h200, 12'h300, 12'h050};
        n_size  = '{12'h000, 12'h300, 12'h000};
        program_map(1'b0);
        sweep("R11 empty windows");

        n_start = '{12'h100, 12'h000, 12'h555, 12'h777};
        n_size  = '{12'h800, 12'h800, 12'h100};
        program_map(1'b1);
        sweep("R6 windows past space");

        finish_run();
    end
endmodule